// File: doc/BRIEF.md
# Virtual Address Translation Unit with TLB and Table Walker

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged memory system with 64-byte pages. A requester offers one virtual address at a time with a valid/ready handshake. The block first looks in a 16-entry translation cache, organised as 4 sets of 4 ways. On a hit it returns the physical address without touching memory.

On a miss it fetches one page-table entry over a simple read port, starting from a page-table base supplied as an input. A valid entry is written into the cache and its physical page number is joined to the untranslated page offset. An invalid entry produces a fault pulse and is not cached. A flush input empties the cache at runtime, and the synchronous reset empties it too.

The result comes back as a one-cycle pulse on `rsp_valid`. `rsp_fault` tells a page fault from a good translation. Only one translation is in flight at a time.

Top module: `vaddr_xlate_unit`

## Requirements
- R1: The low 6 bits of the physical address equal the low 6 bits of the virtual address. The virtual page number is virtual address bits [13:6].
- R2: The cache set is VPN bits [1:0] and the tag is VPN bits [7:2]. A valid entry with a matching tag in that set is a hit. A hit issues no memory read and raises `rsp_valid` on the second rising edge after the request is accepted.
- R3: On a miss exactly one memory read is issued, at address `ptbr + 2*VPN` (16-bit entries, byte addressed). In the returned word, bit 0 is the valid flag and bits [6:1] are the physical page number. The physical address is {PPN, offset}.
- R4: A valid fetched entry is installed in the cache, so a later request to the same page hits.
- R5: A fetched entry with bit 0 clear gives `rsp_fault`=1 and `rsp_pa`=0. It is not installed, so a repeat of that request misses again.
- R6: A fill takes the lowest-numbered empty way of its set. When the set is full, it takes the way named by that set's 2-bit round-robin pointer. The pointer is 0 after reset and advances by one on each fill that evicts.
- R7: `req_ready` is low from acceptance until the result. `mem_req_valid` is a single-cycle pulse, and it is never high while `req_ready` is high.
- R8: A one-cycle `flush` empties every cache entry, so the next request to any page misses.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, and the cache is empty. This holds even if reset arrives in the middle of a table fetch.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 14 | Virtual address to translate |
| ptbr | input | 16 | Byte address of the page table |
| mem_req_valid | output | 1 | Page-table read request, one-cycle pulse |
| mem_req_addr | output | 16 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 16 | Page-table entry word |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | 12 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Entry was not valid |

## Verification
A corrupted tag, physical page number or valid bit in the cache shows up on the very next request to that set. It appears either as a wrong `rsp_pa` two edges after acceptance, or as a read on `mem_req_addr` where a hit was due. A wrong round-robin pointer stays hidden until a full set evicts. It then surfaces one request later, as a page that misses when it should hit, or the reverse. A controller stuck in its fetch states shows as `req_ready` staying low, and the next request is refused.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

   // Controller phases for one translation
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_LOOK  = 2'd1,
      WK_FETCH = 2'd2,
      WK_WAIT  = 2'd3
   } walk_state_t;

   // Index width that never drops to zero bits
   function automatic int clog2_min1(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mmu_way_pick.sv
module mmu_way_pick #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]  vld,
   input  logic [WAY_W-1:0] ptr,
   output logic [WAY_W-1:0] way,
   output logic             from_ptr
);

   generate
      if (WAYS == 1) begin : g_direct
         // Only one place to go; pointer is never consulted
         logic ptr_unused;
         logic vld_unused;
         assign ptr_unused = ^ptr;
         assign vld_unused = ^vld;
         assign way        = '0;
         assign from_ptr   = 1'b0;
      end else begin : g_assoc
         // Lowest empty way wins; scan downward so the last hit is the lowest
         always_comb begin
            way      = ptr;
            from_ptr = 1'b1;
            for (int w = WAYS - 1; w >= 0; w--) begin
               if (!vld[w]) begin
                  way      = WAY_W'(w);
                  from_ptr = 1'b0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mmu_tlb_store.sv
module mmu_tlb_store
   import mmu_pkg::*;
#(
   parameter int VPN_W = 8,
   parameter int PPN_W = 6,
   parameter int SETS  = 4,
   parameter int WAYS  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush,
   input  logic [VPN_W-1:0] key_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             fill_en,
   input  logic [PPN_W-1:0] fill_ppn
);

   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int WAY_W = clog2_min1(WAYS);

   logic [WAYS-1:0]  vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [PPN_W-1:0] ppn_q [SETS][WAYS];
   logic [WAY_W-1:0] rr_q  [SETS];

   logic [IDX_W-1:0] key_idx;
   logic [TAG_W-1:0] key_tag;
   logic [WAYS-1:0]  hit_vec;
   logic [WAY_W-1:0] vic_way;
   logic             vic_from_ptr;

   assign key_idx = key_vpn[IDX_W-1:0];
   assign key_tag = key_vpn[VPN_W-1:IDX_W];

   // Parallel tag compare across the ways of the indexed set
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign hit_vec[w] = vld_q[key_idx][w] && (tag_q[key_idx][w] == key_tag);
      end
   endgenerate

   always_comb begin
      lk_ppn = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) lk_ppn = lk_ppn | ppn_q[key_idx][w];
      end
   end
   assign lk_hit = |hit_vec;

   mmu_way_pick #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_pick (
      .vld      (vld_q[key_idx]),
      .ptr      (rr_q[key_idx]),
      .way      (vic_way),
      .from_ptr (vic_from_ptr)
   );

   // Valid bits and pointers: reset and flush clear, flush beats a fill
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            rr_q[s]  <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (fill_en) begin
         vld_q[key_idx][vic_way] <= 1'b1;
         if (vic_from_ptr) rr_q[key_idx] <= rr_q[key_idx] + WAY_W'(1);
      end
   end

   // Payload needs no reset; it is qualified by the valid bits
   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag_q[key_idx][vic_way] <= key_tag;
         ppn_q[key_idx][vic_way] <= fill_ppn;
      end
   end

   // R2: fills only on misses, so a tag never sits twice in one set
   p_hit_unique_r2 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));

   // R8: after a flush nothing can hit
   p_flush_clears_r8 : assert property (@(posedge clk) disable iff (rst)
      flush |=> !lk_hit);

   // R4: the controller installs only pages that missed
   p_fill_on_miss_r4 : assert property (@(posedge clk) disable iff (rst)
      fill_en |-> !lk_hit);

endmodule

// File: rtl/mmu_walk_ctl.sv
module mmu_walk_ctl
   import mmu_pkg::*;
#(
   parameter int VA_W      = 14,
   parameter int PA_W      = 12,
   parameter int OFF_W     = 6,
   parameter int PPN_W     = 6,
   parameter int MADDR_W   = 16,
   parameter int PTE_W     = 16,
   parameter int PTE_SHIFT = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_va,
   input  logic [MADDR_W-1:0]    ptbr,
   output logic                  mem_req_valid,
   output logic [MADDR_W-1:0]    mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [PTE_W-1:0]      mem_rsp_data,
   output logic [VA_W-OFF_W-1:0] key_vpn,
   input  logic                  tlb_hit,
   input  logic [PPN_W-1:0]      tlb_ppn,
   output logic                  fill_en,
   output logic [PPN_W-1:0]      fill_ppn,
   output logic                  rsp_valid,
   output logic [PA_W-1:0]       rsp_pa,
   output logic                  rsp_fault
);

   localparam int VPN_W = VA_W - OFF_W;

   walk_state_t      st_q;
   logic [VA_W-1:0]  va_q;
   logic             pte_ok;
   logic [PPN_W-1:0] pte_ppn;
   logic             pte_unused;

   assign key_vpn    = va_q[VA_W-1:OFF_W];
   assign pte_ok     = mem_rsp_data[0];
   assign pte_ppn    = mem_rsp_data[PPN_W:1];
   assign pte_unused = ^mem_rsp_data[PTE_W-1:PPN_W+1];

   assign req_ready     = (st_q == WK_IDLE);
   assign mem_req_valid = (st_q == WK_FETCH);
   assign mem_req_addr  = ptbr + (MADDR_W'(key_vpn) << PTE_SHIFT);
   assign fill_en       = (st_q == WK_WAIT) && mem_rsp_valid && pte_ok;
   assign fill_ppn      = pte_ppn;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= WK_IDLE;
         va_q      <= '0;
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            WK_IDLE: begin
               if (req_valid) begin
                  va_q <= req_va;
                  st_q <= WK_LOOK;
               end
            end
            WK_LOOK: begin
               if (tlb_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_pa    <= {tlb_ppn, va_q[OFF_W-1:0]};
                  rsp_fault <= 1'b0;
                  st_q      <= WK_IDLE;
               end else begin
                  st_q <= WK_FETCH;
               end
            end
            WK_FETCH: st_q <= WK_WAIT;
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  st_q      <= WK_IDLE;
                  if (pte_ok) begin
                     rsp_pa    <= {pte_ppn, va_q[OFF_W-1:0]};
                     rsp_fault <= 1'b0;
                  end else begin
                     rsp_pa    <= '0;
                     rsp_fault <= 1'b1;
                  end
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   // R10: results are single-cycle pulses
   p_rsp_pulse_r10 : assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);

   // R7: one read per miss, never while accepting
   p_memreq_pulse_r7 : assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |=> !mem_req_valid);
   p_busy_not_ready_r7 : assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> !req_ready);

   // R5: a fault carries no address
   p_fault_pa_zero_r5 : assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

   // R1: page offset passes through
   p_offset_pass_r1 : assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

   // R2: a hit never reaches memory
   p_hit_no_mem_r2 : assert property (@(posedge clk) disable iff (rst)
      ((st_q == WK_LOOK) && tlb_hit) |=> !mem_req_valid);

endmodule

// File: rtl/vaddr_xlate_unit.sv
module vaddr_xlate_unit #(
   parameter int VA_W      = 14,
   parameter int PA_W      = 12,
   parameter int OFF_W     = 6,
   parameter int TLB_SETS  = 4,
   parameter int TLB_WAYS  = 4,
   parameter int MADDR_W   = 16,
   parameter int PTE_W     = 16,
   parameter int PTE_BYTES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               flush,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_va,
   input  logic [MADDR_W-1:0] ptbr,
   output logic               mem_req_valid,
   output logic [MADDR_W-1:0] mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               rsp_valid,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_fault
);

   localparam int VPN_W     = VA_W - OFF_W;
   localparam int PPN_W     = PA_W - OFF_W;
   localparam int PTE_SHIFT = $clog2(PTE_BYTES);

   // Elaboration-time parameter checks
   generate
      if (VPN_W <= $clog2(TLB_SETS)) begin : g_bad_vpn
         $error("virtual page number too narrow for the set count");
      end
      if (PPN_W < 1) begin : g_bad_ppn
         $error("physical address has no page number bits");
      end
      if (PTE_W < PPN_W + 2) begin : g_bad_pte
         $error("entry word cannot hold a valid flag and page number");
      end
      if ((TLB_SETS < 2) || ((TLB_SETS & (TLB_SETS - 1)) != 0)) begin : g_bad_sets
         $error("set count must be a power of two, at least 2");
      end
      if ((TLB_WAYS & (TLB_WAYS - 1)) != 0) begin : g_bad_ways
         $error("way count must be a power of two");
      end
      if ((PTE_BYTES & (PTE_BYTES - 1)) != 0) begin : g_bad_bytes
         $error("entry size must be a power of two");
      end
      if (MADDR_W < VPN_W + PTE_SHIFT) begin : g_bad_maddr
         $error("memory address too narrow for the page table");
      end
   endgenerate

   logic [VPN_W-1:0] key_vpn;
   logic             tlb_hit;
   logic [PPN_W-1:0] tlb_ppn;
   logic             fill_en;
   logic [PPN_W-1:0] fill_ppn;

   mmu_walk_ctl #(
      .VA_W      (VA_W),
      .PA_W      (PA_W),
      .OFF_W     (OFF_W),
      .PPN_W     (PPN_W),
      .MADDR_W   (MADDR_W),
      .PTE_W     (PTE_W),
      .PTE_SHIFT (PTE_SHIFT)
   ) u_ctl (
      .clk           (clk),
      .rst           (rst),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_va        (req_va),
      .ptbr          (ptbr),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .key_vpn       (key_vpn),
      .tlb_hit       (tlb_hit),
      .tlb_ppn       (tlb_ppn),
      .fill_en       (fill_en),
      .fill_ppn      (fill_ppn),
      .rsp_valid     (rsp_valid),
      .rsp_pa        (rsp_pa),
      .rsp_fault     (rsp_fault)
   );

   mmu_tlb_store #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .SETS  (TLB_SETS),
      .WAYS  (TLB_WAYS)
   ) u_tlb (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .key_vpn  (key_vpn),
      .lk_hit   (tlb_hit),
      .lk_ppn   (tlb_ppn),
      .fill_en  (fill_en),
      .fill_ppn (fill_ppn)
   );

endmodule

// File: tb/vaddr_xlate_unit_test.sv
`timescale 1ns/1ps
module vaddr_xlate_unit_test;

   localparam logic [15:0] PTB = 16'h0400;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [13:0] req_va = '0;
   logic [15:0] ptbr = PTB;
   logic        mem_req_valid;
   logic [15:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic [11:0] rsp_pa;
   logic        rsp_fault;

   int tests = 0;
   int fails = 0;
   int mreq_cnt = 0;
   int mem_lat = 1;
   logic [15:0] last_addr = '0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   vaddr_xlate_unit uut (
      .clk(clk), .rst(rst), .flush(flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .ptbr(ptbr),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
   );

   // Bench page table: bit0 valid, bits[6:1] page number
   function automatic logic [15:0] pte_word(input logic [7:0] vpn);
      logic v;
      logic [5:0] p;
      v = 1'b0; p = 6'h00;
      case (vpn)
         8'h00: begin v = 1; p = 6'h28; end
         8'h02: begin v = 1; p = 6'h33; end
         8'h03: begin v = 1; p = 6'h02; end
         8'h05: begin v = 1; p = 6'h16; end
         8'h08: begin v = 1; p = 6'h13; end
         8'h09: begin v = 1; p = 6'h17; end
         8'h0A: begin v = 1; p = 6'h09; end
         8'h0D: begin v = 1; p = 6'h2D; end
         8'h0E: begin v = 1; p = 6'h11; end
         8'h0F: begin v = 1; p = 6'h0D; end
         8'h01, 8'h04, 8'h06, 8'h07, 8'h0B, 8'h0C: v = 0;
         default: begin
            v = (int'(vpn) % 3) != 0;
            p = 6'((int'(vpn) * 5 + 3) % 64);
         end
      endcase
      return {9'h000, (v ? p : 6'h3F), v};
   endfunction

   // Memory model: answers each read after mem_lat cycles
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            logic [15:0] a;
            a = mem_req_addr;
            mreq_cnt++;
            last_addr = a;
            repeat (mem_lat - 1) @(negedge clk);
            @(negedge clk);
            mem_rsp_data  = pte_word(8'((a - PTB) >> 1));
            mem_rsp_valid = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic xlate(input logic [13:0] va, input logic exp_miss,
                        input logic exp_fault, input logic [11:0] exp_pa,
                        input string rq);
      int base, waited;
      bit got, busy_ready;
      base = mreq_cnt;
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = va;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
      waited = 0; got = 0; busy_ready = 0;
      while (!got && waited < 40) begin
         @(negedge clk);
         waited++;
         if (mem_req_valid && req_ready) busy_ready = 1;
         if (rsp_valid) got = 1;
      end
      chk(got, rq, "response seen", got, 1);
      chk(!busy_ready, "R7", "read with ready high", busy_ready, 0);
      chk(rsp_pa == exp_pa, rq, "pa (R1)", rsp_pa, exp_pa);
      chk(rsp_fault == exp_fault, rq, "fault", rsp_fault, exp_fault);
      chk((mreq_cnt - base) == int'(exp_miss), rq, "memory reads", mreq_cnt - base, exp_miss);
      if (exp_miss)
         chk(last_addr == PTB + {7'd0, va[13:6], 1'b0}, "R3", "entry address",
             last_addr, PTB + {7'd0, va[13:6], 1'b0});
      else
         chk(waited == 1, "R2", "hit latency", waited, 1);
      @(negedge clk);
      chk(!rsp_valid, "R10", "pulse width", rsp_valid, 0);
   endtask

   // Expected values from the bench page table
   task automatic xm(input logic [13:0] va, input logic exp_miss, input string rq);
      logic [15:0] w;
      w = pte_word(va[13:6]);
      xlate(va, exp_miss, !w[0], w[0] ? {w[6:1], va[5:0]} : 12'h000, rq);
   endtask

   // {va, miss, fault, pa}
   localparam logic [27:0] VEC [10] = '{
      {14'h0020, 1'b1, 1'b0, 12'hA20},
      {14'h03D4, 1'b1, 1'b0, 12'h354},
      {14'h03D4, 1'b0, 1'b0, 12'h354},
      {14'h0040, 1'b1, 1'b1, 12'h000},
      {14'h0040, 1'b1, 1'b1, 12'h000},
      {14'h0020, 1'b0, 1'b0, 12'hA20},
      {14'h00BF, 1'b1, 1'b0, 12'hCFF},
      {14'h00FF, 1'b1, 1'b0, 12'h0BF},
      {14'h0345, 1'b1, 1'b0, 12'hB45},
      {14'h0345, 1'b0, 1'b0, 12'hB45}
   };

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: reset state
      chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
      chk(mem_req_valid == 1'b0, "R9", "mem_req after reset", mem_req_valid, 0);

      // Table: R2 hits, R3 misses, R4 fills, R5 faults
      for (int i = 0; i < 10; i++) begin
         logic [27:0] v;
         v = VEC[i];
         xlate(v[27:14], v[13], v[12], v[11:0],
               v[13] ? (v[12] ? "R5" : "R3/R4") : "R2");
      end

      // R8: flush empties the cache
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      xm(14'h03D4, 1'b1, "R8");
      xm(14'h0345, 1'b1, "R8");

      // R6: fill set 0; a fault must not take a way
      mem_lat = 3;
      xm(14'h0011, 1'b1, "R6");   // vpn 00 -> way0
      xm(14'h0222, 1'b1, "R6");   // vpn 08 -> way1
      xm(14'h0133, 1'b1, "R5");   // vpn 04 invalid
      xm(14'h0404, 1'b1, "R6");   // vpn 10 -> way2
      xm(14'h0505, 1'b1, "R6");   // vpn 14 -> way3
      xm(14'h0000, 1'b0, "R6");
      xm(14'h0200, 1'b0, "R6");
      xm(14'h0400, 1'b0, "R6");
      xm(14'h0500, 1'b0, "R6");
      xm(14'h073F, 1'b1, "R6");   // vpn 1C evicts way0 (vpn 00)
      xm(14'h0001, 1'b1, "R6");   // vpn 00 evicts way1 (vpn 08)
      xm(14'h0400, 1'b0, "R6");
      xm(14'h0500, 1'b0, "R6");
      xm(14'h0700, 1'b0, "R6");
      xm(14'h0000, 1'b0, "R6");
      xm(14'h0200, 1'b1, "R6");   // vpn 08 was the victim
      mem_lat = 1;

      // R9: reset in the middle of a fetch
      mem_lat = 3;
      @(negedge clk); req_valid = 1'b1; req_va = 14'h0940;
      @(negedge clk); req_valid = 1'b0;
      while (!mem_req_valid) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
      chk(mem_req_valid == 1'b0, "R9", "mem_req in reset", mem_req_valid, 0);
      rst = 1'b0;
      repeat (6) @(negedge clk);
      chk(rsp_valid == 1'b0, "R10", "no stray result", rsp_valid, 0);
      mem_lat = 1;
      xm(14'h03D4, 1'b1, "R9");
      xm(14'h0940, 1'b1, "R9");
      xm(14'h0940, 1'b0, "R4");

      done = 1;
      finish_up();
   end

endmodule